// File: doc/BRIEF.md
# Programmable Sinc3 Decimation Filter

This block turns a one-bit oversampled bitstream into signed 24-bit conversion results. It runs a three-stage cascaded integrator-comb (sinc3) filter. The decimation ratio is 64 times a 10-bit rate code. The bitstream arrives through a sample-enable strobe, so the block can sit in any clock domain that is faster than the sample rate.

On top of the filter sits a settling qualifier, which decides which comb outputs become visible results.
- After reset or after a channel restart, the filter is cleared. Results stay hidden until three full decimation periods have been collected.
- In continuous mode, a result is then presented every period.
- In zero-latency mode, the filter clears itself after each result. Every result is therefore fully settled, at one third of the continuous rate.
- The rate code and the mode bit are taken only at reset and at a restart, so a change of rate always starts from a clean filter.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is low and `res_word` is zero.
- R2: A sample of 1 counts as +1 and a sample of 0 counts as -1. At rate code 1, a settled all-ones input gives 0x7FFFFF, which is saturated. A settled all-zeros input gives 0x800000. Results are two's complement.
- R3: At rate code 1, a repeating 4-sample pattern gives a fixed settled result. The pattern bit for sample index i after a restart is pat[i mod 4]. The pattern 0101 gives 0x000000. The pattern 0111 (three ones in four) gives 0x400000.
- R4: The raw filter sum is shifted by 3·ceil(log2(64·FS)) − 23 bits. A positive amount shifts right and a negative amount shifts left. The result then saturates to 24 bits. For example, at FS=3 constant ones give 0x360000 and constant zeros give 0xCA0000.
- R5: A rate code of 0 behaves exactly like a rate code of 1.
- R6: In continuous mode, the first result follows the enabled sample with index 3·64·FS−1 after a restart. Later results follow every 64·FS enabled samples. `res_valid` is a one-cycle pulse in the clock after that sample.
- R7: A restart pulse discards all filter state, including a partly collected period. The next result then needs three fresh periods and depends only on samples taken after the restart.
- R8: When the mode bit is latched as 1, results follow sample indices 3·64·FS·m − 1 for m = 1, 2, 3 and so on. Each result is computed from a freshly cleared filter.
- R9: Changes on `rate_code` and `zero_lat` between restarts have no effect on timing or values.
- R10: Cycles with `samp_en` low change no state. The value of `mod_bit` in those cycles is ignored. Only enabled samples set timing and values.
- R11: In continuous mode, a step of the input that lands exactly on a period boundary does not interrupt the result stream. The third result after the step is settled; the second is not.
- R12: A step that lands inside a period needs four results before the result is settled; the third result after the step is not settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also latches the rate code and mode bit |
| samp_en | input | 1 | High for one cycle per modulator sample |
| mod_bit | input | 1 | Modulator bitstream, sampled when `samp_en` is high |
| rate_code | input | 10 | Decimation code FS; ratio is 64·FS, 0 treated as 1 |
| zero_lat | input | 1 | Zero-latency mode select, latched at reset and restart |
| chan_restart | input | 1 | One-cycle pulse: clear the filter and latch the configuration |
| res_valid | output | 1 | One-cycle pulse when a new result is available |
| res_word | output | 24 | Signed result, held between pulses |

## Verification
The bench aims at the qualifier edges where an off-by-one is easy to make.
- A design that counts two or four periods before the first result would place its pulses one period early or late.
- A design that leaves integrator residue after a mid-period restart would report a value that is not exactly 0x800000 after a switch from ones to zeros.
- The zero-latency runs would expose a missing self-clear, because results would then come every period instead of every third.
- The gap test drives inverted bits on idle cycles. The rate-change test moves the code without a restart. Both catch designs that let unqualified inputs leak in.
- The step tests pin down the three-versus-four result settling rule.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int RATE_W   = 10;
  localparam int OSR_UNIT = 64;
  localparam int OUT_W    = 24;
  localparam int STAGES   = 3;
  localparam int MAX_R    = OSR_UNIT * ((1 << RATE_W) - 1);
  localparam int CNT_W    = $clog2(MAX_R);
  localparam int ACC_W    = STAGES * CNT_W + 1;
  localparam int SET_W    = 2;

  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t SAT_HI = acc_t'((1 << (OUT_W - 1)) - 1);
  localparam acc_t SAT_LO = ~SAT_HI;

  // smallest k with 2**k >= n
  function automatic int ceil_log2(input int n);
    int res;
    res = 0;
    for (int k = 31; k >= 0; k--) begin
      if ((longint'(1) << k) >= longint'(n)) res = k;
    end
    return res;
  endfunction

  function automatic logic [RATE_W-1:0] legal_rate(input logic [RATE_W-1:0] code);
    return (code == '0) ? RATE_W'(1) : code;
  endfunction

  function automatic int dec_ratio(input logic [RATE_W-1:0] fs);
    return OSR_UNIT * int'(fs);
  endfunction

  // align the filter sum so that full scale lands on the 24-bit MSB
  function automatic logic [OUT_W-1:0] scale_word(input acc_t v, input logic [RATE_W-1:0] fs);
    int   sh;
    acc_t t;
    sh = STAGES * ceil_log2(dec_ratio(fs)) - (OUT_W - 1);
    if (sh >= 0) t = v >>> sh;
    else         t = v <<< (-sh);
    if (t > SAT_HI)      t = SAT_HI;
    else if (t < SAT_LO) t = SAT_LO;
    return t[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ
  import sinc3_pkg::*;
#(
  parameter int N = STAGES,
  parameter int W = ACC_W
) (
  input  logic                clk,
  input  logic                clear,
  input  logic                step,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] sum_next
);
  logic signed [W-1:0] st_q [N];
  logic signed [W-1:0] st_d [N];

  // each stage adds the freshly updated value of the stage before it
  always_comb begin
    for (int g = 0; g < N; g++) begin
      if (g == 0) st_d[g] = st_q[g] + din;
      else        st_d[g] = st_q[g] + st_d[g-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < N; g++) begin
      if (clear)     st_q[g] <= '0;
      else if (step) st_q[g] <= st_d[g];
    end
  end

  assign sum_next = st_d[N-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
  import sinc3_pkg::*;
#(
  parameter int N = STAGES,
  parameter int W = ACC_W
) (
  input  logic                clk,
  input  logic                clear,
  input  logic                fire,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] dly_q [N];
  logic signed [W-1:0] dif   [N+1];

  always_comb begin
    dif[0] = din;
    for (int g = 0; g < N; g++) dif[g+1] = dif[g] - dly_q[g];
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < N; g++) begin
      if (clear)     dly_q[g] <= '0;
      else if (fire) dly_q[g] <= dif[g];
    end
  end

  assign dout = dif[N];
endmodule

// File: rtl/sinc3_seq.sv
module sinc3_seq
  import sinc3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              chan_restart,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              zero_lat,
  output logic [RATE_W-1:0] rate_q,
  output logic              zl_q,
  output logic              clear,
  output logic              fire,
  output logic              present,
  output logic [SET_W-1:0]  settle_q,
  output logic [CNT_W-1:0]  dcnt_q
);
  localparam logic [SET_W-1:0] SETTLED = SET_W'(STAGES - 1);

  logic             take_cfg;
  logic [CNT_W-1:0] last_idx;

  assign take_cfg = !rst_n || chan_restart;
  assign last_idx = CNT_W'(dec_ratio(rate_q) - 1);
  assign fire     = rst_n && samp_en && !chan_restart && (dcnt_q == last_idx);
  assign present  = fire && (settle_q == SETTLED);
  assign clear    = take_cfg || (present && zl_q);

  always_ff @(posedge clk) begin
    if (take_cfg) begin
      rate_q <= legal_rate(rate_code);
      zl_q   <= zero_lat;
    end
  end

  always_ff @(posedge clk) begin
    if (clear)        dcnt_q <= '0;
    else if (samp_en) dcnt_q <= fire ? '0 : dcnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (clear)                             settle_q <= '0;
    else if (fire && settle_q != SETTLED)  settle_q <= settle_q + SET_W'(1);
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              mod_bit,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              zero_lat,
  input  logic              chan_restart,
  output logic              res_valid,
  output logic [OUT_W-1:0]  res_word
);
  // named internal events, observed by the bound checker
  logic              dec_evt;
  logic              pres_evt;
  logic              filt_clear;
  logic              zl_mode;
  logic [RATE_W-1:0] rate_eff;
  logic [SET_W-1:0]  settle_cnt;
  logic [CNT_W-1:0]  dec_cnt;
  acc_t              samp_val;
  acc_t              integ_sum;
  acc_t              comb_out;

  assign samp_val = mod_bit ? acc_t'(1) : '1;

  sinc3_seq u_seq (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .chan_restart(chan_restart),
    .rate_code(rate_code), .zero_lat(zero_lat),
    .rate_q(rate_eff), .zl_q(zl_mode), .clear(filt_clear), .fire(dec_evt),
    .present(pres_evt), .settle_q(settle_cnt), .dcnt_q(dec_cnt)
  );

  sinc3_integ #(.N(STAGES), .W(ACC_W)) u_integ (
    .clk(clk), .clear(filt_clear), .step(samp_en), .din(samp_val), .sum_next(integ_sum)
  );

  sinc3_comb #(.N(STAGES), .W(ACC_W)) u_comb (
    .clk(clk), .clear(filt_clear), .fire(dec_evt), .din(integ_sum), .dout(comb_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= pres_evt;
      if (pres_evt) res_word <= scale_word(comb_out, rate_eff);
    end
  end
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk
  import sinc3_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              samp_en,
  input logic              chan_restart,
  input logic              res_valid,
  input logic              dec_evt,
  input logic              zl_mode,
  input logic [RATE_W-1:0] rate_eff,
  input logic [SET_W-1:0]  settle_cnt,
  input logic [CNT_W-1:0]  dec_cnt
);
  assert_restart_mutes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_restart |=> !res_valid);

  assert_valid_after_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(dec_evt) && $past(settle_cnt) == SET_W'(STAGES - 1)));

  assert_settle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    settle_cnt <= SET_W'(STAGES - 1));

  assert_zl_rewinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && zl_mode) |-> (settle_cnt == '0 && dec_cnt == '0));

  assert_rate_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rate_eff != '0);

  assert_hold_without_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_en && !chan_restart) |=> $stable(dec_cnt));

  assert_valid_needs_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(samp_en));
endmodule

bind sinc3_decim sinc3_decim_chk u_chk (
  .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .chan_restart(chan_restart),
  .res_valid(res_valid), .dec_evt(dec_evt), .zl_mode(zl_mode), .rate_eff(rate_eff),
  .settle_cnt(settle_cnt), .dec_cnt(dec_cnt)
);

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        samp_en;
  logic        mod_bit;
  logic [9:0]  rate_code;
  logic        zero_lat;
  logic        chan_restart;
  logic        res_valid;
  logic [23:0] res_word;

  always #5 clk = ~clk;

  sinc3_decim u0 (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .mod_bit(mod_bit),
    .rate_code(rate_code), .zero_lat(zero_lat), .chan_restart(chan_restart),
    .res_valid(res_valid), .res_word(res_word)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  int          sidx;
  int          vcnt;
  int          vpos [16];
  logic [23:0] vval [16];

  // {fs[9:0], zero_lat, pattern[3:0], expected[23:0]}
  localparam int NV = 9;
  localparam logic [38:0] VEC [NV] = '{
    {10'd1, 1'b0, 4'b1111, 24'h7FFFFF},
    {10'd1, 1'b0, 4'b0000, 24'h800000},
    {10'd1, 1'b0, 4'b0101, 24'h000000},
    {10'd1, 1'b0, 4'b0111, 24'h400000},
    {10'd1, 1'b1, 4'b1111, 24'h7FFFFF},
    {10'd3, 1'b0, 4'b1111, 24'h360000},
    {10'd0, 1'b0, 4'b0111, 24'h400000},
    {10'd2, 1'b1, 4'b0001, 24'hC00000},
    {10'd3, 1'b1, 4'b0000, 24'hCA0000}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic note(input int pos);
    if (res_valid && vcnt < 16) begin
      vpos[vcnt] = pos;
      vval[vcnt] = res_word;
      vcnt++;
    end
  endtask

  task automatic restart(input logic [9:0] fs, input logic zl);
    rate_code    = fs;
    zero_lat     = zl;
    samp_en      = 1'b0;
    chan_restart = 1'b1;
    @(posedge clk); #1;
    chan_restart = 1'b0;
    sidx = 0;
    vcnt = 0;
  endtask

  // step_at < 0: pattern mode; otherwise zeros before step_at, ones from it
  task automatic run(input int n, input logic [3:0] pat, input int gap, input int step_at);
    for (int i = 0; i < n; i++) begin
      samp_en = 1'b1;
      mod_bit = (step_at < 0) ? pat[sidx % 4] : (sidx >= step_at);
      @(posedge clk); #1;
      samp_en = 1'b0;
      note(sidx);
      for (int g = 0; g < gap; g++) begin
        mod_bit = ~mod_bit;
        @(posedge clk); #1;
        note(-1);
      end
      sidx++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; samp_en = 1'b0; mod_bit = 1'b0; rate_code = 10'd1;
    zero_lat = 1'b0; chan_restart = 1'b0; sidx = 0; vcnt = 0;
    repeat (3) @(posedge clk); #1;
    chk(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
    chk(res_word == 24'h0, "R1 word in reset", res_word, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(res_valid == 1'b0 && res_word == 24'h0, "R1 after release", res_word, 0);

    // table walk: count, placement and value of every result
    for (int v = 0; v < NV; v++) begin
      logic [9:0]  fs;
      logic        zl;
      logic [3:0]  pat;
      logic [23:0] exp;
      int          r;
      int          nexp;
      string       tv;
      string       tp;
      fs  = VEC[v][38:29];
      zl  = VEC[v][28];
      pat = VEC[v][27:24];
      exp = VEC[v][23:0];
      r   = 64 * ((fs == 10'd0) ? 1 : int'(fs));
      case (v)
        0, 1:    tv = "R2";
        2, 3:    tv = "R3";
        5, 8:    tv = "R4";
        6:       tv = "R5";
        default: tv = "R8";
      endcase
      tp = zl ? "R8 position" : ((fs == 10'd0) ? "R5 position" : "R6 position");
      restart(fs, zl);
      run(9 * r, pat, 0, -1);
      nexp = zl ? 3 : 7;
      chk(vcnt == nexp, zl ? "R8 count" : "R6 count", vcnt, nexp);
      for (int j = 0; j < vcnt && j < nexp; j++) begin
        int p;
        p = zl ? (3 * (j + 1) * r - 1) : ((3 + j) * r - 1);
        chk(vpos[j] == p, tp, vpos[j], p);
        chk(vval[j] == exp, tv, vval[j], exp);
      end
    end

    // R7: restart mid-period after ones, then zeros only
    restart(10'd1, 1'b0);
    run(230, 4'b1111, 0, -1);
    restart(10'd1, 1'b0);
    run(192, 4'b0000, 0, -1);
    chk(vcnt == 1, "R7 count", vcnt, 1);
    chk(vpos[0] == 191, "R7 position", vpos[0], 191);
    chk(vval[0] == 24'h800000, "R7 value", vval[0], 24'h800000);

    // R9: rate code and mode change without restart are ignored
    restart(10'd1, 1'b0);
    run(100, 4'b1111, 0, -1);
    rate_code = 10'd3;
    zero_lat  = 1'b1;
    run(476, 4'b1111, 0, -1);
    chk(vcnt == 7, "R9 count", vcnt, 7);
    chk(vpos[6] == 575, "R9 last position", vpos[6], 575);
    chk(vval[6] == 24'h7FFFFF, "R9 value", vval[6], 24'h7FFFFF);

    // R10: idle cycles between samples with inverted bits
    restart(10'd1, 1'b0);
    run(192, 4'b0111, 2, -1);
    chk(vcnt == 1, "R10 count", vcnt, 1);
    chk(vpos[0] == 191, "R10 position", vpos[0], 191);
    chk(vval[0] == 24'h400000, "R10 value", vval[0], 24'h400000);

    // R11: step on a period boundary
    restart(10'd1, 1'b0);
    run(576, 4'b0000, 0, 320);
    chk(vcnt == 7, "R11 stream continues", vcnt, 7);
    chk(vval[2] == 24'h800000, "R11 pre-step", vval[2], 24'h800000);
    chk(vval[4] != 24'h7FFFFF, "R11 second after step unsettled", vval[4], 24'h7FFFFF);
    chk(vval[5] == 24'h7FFFFF, "R11 third after step settled", vval[5], 24'h7FFFFF);

    // R12: step inside a period
    restart(10'd1, 1'b0);
    run(640, 4'b0000, 0, 352);
    chk(vcnt == 8, "R12 count", vcnt, 8);
    chk(vval[5] != 24'h7FFFFF, "R12 third after step unsettled", vval[5], 24'h7FFFFF);
    chk(vval[6] == 24'h7FFFFF, "R12 fourth after step settled", vval[6], 24'h7FFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule